// File: doc/BRIEF.md
# Shift-Add Twiddle Rotator

This block rotates a 16-bit signed vector (x, y) counter-clockwise by one of sixteen fixed angles. The angles are the twiddle angles of a 32-point transform, idx × 11.25° for idx = 0 to 15. A memory-based FFT can hand every twiddle multiplication to this block and needs no complex constant multiplier. The block has no multiplier and never corrects a scale factor. Each micro-rotation builds sine and cosine from a fourth-order Taylor series made only of arithmetic shifts and adds. With those terms the gain of every step is almost exactly one.

The angles are known in advance, so the block does not run a fixed ladder of iterations. A small lookup, indexed by angle number, supplies three things: an exact pre-rotation (none, a quarter turn or a half turn), an iteration count of 0 to 6, and a list of shift values with their directions. Only the listed steps run, one per clock. On its own, the micro-rotation chain covers residual angles up to about 57°. The pre-rotation extends the reach to the full half circle.

The user pulses start with a vector and an angle index and waits for the one-cycle done pulse. The rounded, saturated result sits on the outputs from that pulse until the next result replaces it.

Top module: `ts_cordic_rotator`

## Requirements
- R1: For every index 0 to 15 and any input vector of magnitude up to 30000, each output is within 20 LSB of the exact counter-clockwise rotation by idx × 11.25° (rounded, then clamped to the 16-bit range). ang_idx is an unsigned 4-bit number.
- R2: Index 0 returns the input vector bit-exactly, including the value -32768.
- R3: Index 8 is an exact quarter turn. out_x equals -in_y clamped to 16 bits, and out_y equals in_x.
- R4: done is high in the cycle that follows the n+2-th rising edge after the edge that accepts start. Here n is 0 for indices 0 and 8, 4 for indices 1, 7, 9 and 15, and 6 for every other index.
- R5: done stays high for exactly one clock cycle per accepted start.
- R6: start is ignored from the accepting edge until done is raised. A second start in that window changes neither the result nor the latency, and produces no extra done pulse.
- R7: An output whose rotated value exceeds the 16-bit range is clamped to 32767 or -32768.
- R8: While rst_n is low at a rising edge, done, out_x and out_y are cleared to zero on that edge.
- R9: out_x and out_y keep their value after done until the next result is delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a rotation; sampled only when idle |
| ang_idx | input | 4 | Angle number, rotation of idx × 11.25° |
| in_x | input | 16 | Input real part, signed two's complement |
| in_y | input | 16 | Input imaginary part, signed two's complement |
| done | output | 1 | One-cycle pulse when a result is ready |
| out_x | output | 16 | Rotated real part, held until the next result |
| out_y | output | 16 | Rotated imaginary part, held until the next result |

## Verification
The hardest case to reach from the ports is a start request that arrives while a rotation is in flight. The bench raises start again, with a different vector and angle, two cycles after an accepted request. It then confirms three things: the first result is unchanged, its latency is unchanged, and no second done ever appears. The clamping paths are also hard to reach with ordinary data. The bench drives them on purpose with a large diagonal vector at 45° and with -32768 through the pass-through and quarter-turn indices. In every one of those cases the bench can predict the exact result.

// File: rtl/ts_cordic_pkg.sv
// Package: shared constants, the angle-entry type and the function that
// builds each entry of the angle lookup.
// Assumes: angle idx means a counter-clockwise turn of idx*pi/16 and the
// step lists below were chosen for shift-only Taylor micro-rotations.
package ts_cordic_pkg;

    localparam int IDX_W  = 4;
    localparam int N_ANG  = 2 ** IDX_W;
    localparam int MAX_IT = 6;
    localparam int SH_W   = 4;
    localparam int CNT_W  = 3;

    typedef enum logic [1:0] {
        PRE_NONE = 2'd0,
        PRE_Q90  = 2'd1,
        PRE_HALF = 2'd2
    } prerot_e;

    typedef struct packed {
        logic [SH_W-1:0] sh;
        logic            neg;
    } step_t;

    typedef struct packed {
        prerot_e                 pre;
        logic [CNT_W-1:0]        n;
        step_t [MAX_IT-1:0]      st;
    } angle_t;

    // Build one entry: pick the quadrant turn, then the step list for the
    // residual in units of pi/16, mirrored when the residual is negative.
    function automatic angle_t angle_lookup(input logic [IDX_W-1:0] idx);
        angle_t e;
        int     iv;
        int     res;
        int     mag;
        bit     flip;
        int     cnt;
        int     sh [MAX_IT];
        bit     ng [MAX_IT];
        e   = '0;
        iv  = int'(idx);
        if (iv <= 4) begin
            e.pre = PRE_NONE;
            res   = iv;
        end else if (iv <= 12) begin
            e.pre = PRE_Q90;
            res   = iv - 8;
        end else begin
            e.pre = PRE_HALF;
            res   = iv - 16;
        end
        flip = (res < 0);
        mag  = flip ? -res : res;
        cnt  = 0;
        sh   = '{default: 0};
        ng   = '{default: 1'b0};
        case (mag)
            1: begin cnt = 4; sh = '{2, 4, 7, 11, 0, 0};  ng = '{0, 1, 0, 0, 0, 0}; end
            2: begin cnt = 6; sh = '{2, 3, 6, 10, 12, 13}; end
            3: begin cnt = 6; sh = '{2, 2, 4, 6, 7, 9}; end
            4: begin cnt = 6; sh = '{2, 2, 2, 5, 9, 12}; end
            default: cnt = 0;
        endcase
        for (int j = 0; j < MAX_IT; j++) begin
            e.st[j].sh  = SH_W'(sh[j]);
            e.st[j].neg = ng[j] ^ flip;
        end
        e.n = CNT_W'(cnt);
        return e;
    endfunction

endpackage

// File: rtl/ts_angle_rom.sv
// Module: constant angle lookup. One generated entry per angle number,
// then selected by the index.
// Assumes: index width and table depth come from the package.
module ts_angle_rom
    import ts_cordic_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output angle_t           ent_o
);

    angle_t tbl [N_ANG];

    // Fill each table slot with its computed entry.
    for (genvar g = 0; g < N_ANG; g++) begin : g_ent
        assign tbl[g] = angle_lookup(IDX_W'(g));
    end

    // Read the requested entry.
    assign ent_o = tbl[idx_i];

endmodule

// File: rtl/ts_micro_rot.sv
// Module: one shift-add micro-rotation with no gain correction.
// sin ~ 2^-k - 2^-(3k+3), cos ~ 1 - 2^-(2k+1) + 2^-(4k+5).
// neg_i = 0 turns counter-clockwise.
// Assumes: W leaves headroom for about 1.42x growth; shifts past W fill
// with the sign bit.
module ts_micro_rot
    import ts_cordic_pkg::*;
#(
    parameter int W = 22
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    input  logic [SH_W-1:0]     sh_i,
    input  logic                neg_i,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o
);

    localparam int AW = 7;

    logic [AW-1:0]      k_s1;
    logic [AW-1:0]      k_s3;
    logic [AW-1:0]      k_c2;
    logic [AW-1:0]      k_c4;
    logic signed [W-1:0] vin  [2];
    logic signed [W-1:0] vout [2];

    // Derive the four shift distances from the step's shift value.
    always_comb begin
        k_s1 = {{(AW-SH_W){1'b0}}, sh_i};
        k_s3 = k_s1 * AW'(3) + AW'(3);
        k_c2 = k_s1 * AW'(2) + AW'(1);
        k_c4 = k_s1 * AW'(4) + AW'(5);
    end

    assign vin[0] = x_i;
    assign vin[1] = y_i;

    // Per axis: cosine part of own value plus or minus sine part of the other.
    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam bit SUB_BASE = (g == 0);
        logic signed [W-1:0] own;
        logic signed [W-1:0] oth;
        logic signed [W-1:0] c_part;
        logic signed [W-1:0] s_part;
        assign own    = vin[g];
        assign oth    = vin[1-g];
        assign c_part = own - (own >>> k_c2) + (own >>> k_c4);
        assign s_part = (oth >>> k_s1) - (oth >>> k_s3);
        assign vout[g] = (SUB_BASE ^ neg_i) ? (c_part - s_part) : (c_part + s_part);
    end

    assign x_o = vout[0];
    assign y_o = vout[1];

endmodule

// File: rtl/ts_round_sat.sv
// Module: drop the guard bits with round-half-up, then clamp to W_OUT bits.
// Assumes: W_IN > W_OUT + G and G >= 1.
module ts_round_sat #(
    parameter int W_IN  = 22,
    parameter int W_OUT = 16,
    parameter int G     = 4
) (
    input  logic signed [W_IN-1:0]  v_i,
    output logic signed [W_OUT-1:0] v_o
);

    localparam logic signed [W_IN-1:0] HALF_LSB = W_IN'(2 ** (G - 1));
    localparam logic signed [W_IN-1:0] MAX_V    = W_IN'(2 ** (W_OUT - 1) - 1);
    localparam logic signed [W_IN-1:0] MIN_V    = -MAX_V - W_IN'(1);

    logic signed [W_IN-1:0] scaled;

    // Round to nearest and remove the guard bits.
    assign scaled = (v_i + HALF_LSB) >>> G;

    // Clamp to the output range.
    always_comb begin
        if (scaled > MAX_V)      v_o = MAX_V[W_OUT-1:0];
        else if (scaled < MIN_V) v_o = MIN_V[W_OUT-1:0];
        else                     v_o = scaled[W_OUT-1:0];
    end

endmodule

// File: rtl/ts_cordic_rotator.sv
// Module: top of the iterative twiddle rotator.
// Flow: accept start when idle, apply the exact pre-rotation, run the
// listed micro-rotations one per clock, then register the rounded result
// and pulse done.
// Assumes: the angle set is fixed by the package lookup; start is only
// sampled in the idle state.
module ts_cordic_rotator
    import ts_cordic_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [IDX_W-1:0]         ang_idx,
    input  logic signed [DATA_W-1:0] in_x,
    input  logic signed [DATA_W-1:0] in_y,
    output logic                     done,
    output logic signed [DATA_W-1:0] out_x,
    output logic signed [DATA_W-1:0] out_y
);

    localparam int IW = DATA_W + GUARD_W + 2;
    localparam int XW = IW - DATA_W - GUARD_W;

    typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ITER, ST_FIN} state_e;

    state_e              state_q;
    angle_t              ent_q;
    angle_t              rom_ent;
    logic [CNT_W-1:0]    it_q;
    logic signed [IW-1:0] x_q, y_q;
    logic signed [IW-1:0] x_ext, y_ext;
    logic signed [IW-1:0] pre_x, pre_y;
    logic signed [IW-1:0] rot_x, rot_y;
    logic signed [DATA_W-1:0] sat_x, sat_y;
    step_t               cur_step;
    logic                last_step;

    ts_angle_rom u_rom (
        .idx_i (ang_idx),
        .ent_o (rom_ent)
    );

    // Widen inputs: sign bits on top, zero guard bits below.
    assign x_ext = {{XW{in_x[DATA_W-1]}}, in_x, {GUARD_W{1'b0}}};
    assign y_ext = {{XW{in_y[DATA_W-1]}}, in_y, {GUARD_W{1'b0}}};

    // Exact quadrant turn chosen by the latched entry.
    always_comb begin
        pre_x = x_q;
        pre_y = y_q;
        case (ent_q.pre)
            PRE_Q90:  begin pre_x = -y_q; pre_y = x_q;  end
            PRE_HALF: begin pre_x = -x_q; pre_y = -y_q; end
            default:  ;
        endcase
    end

    assign cur_step  = ent_q.st[it_q];
    assign last_step = (it_q == (ent_q.n - CNT_W'(1)));

    ts_micro_rot #(.W(IW)) u_rot (
        .x_i   (x_q),
        .y_i   (y_q),
        .sh_i  (cur_step.sh),
        .neg_i (cur_step.neg),
        .x_o   (rot_x),
        .y_o   (rot_y)
    );

    ts_round_sat #(.W_IN(IW), .W_OUT(DATA_W), .G(GUARD_W)) u_sat_x (
        .v_i (x_q),
        .v_o (sat_x)
    );

    ts_round_sat #(.W_IN(IW), .W_OUT(DATA_W), .G(GUARD_W)) u_sat_y (
        .v_i (y_q),
        .v_o (sat_y)
    );

    // Sequencer and working registers: idle, pre-turn, iterate, deliver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ent_q   <= '0;
            it_q    <= '0;
            x_q     <= '0;
            y_q     <= '0;
            done    <= 1'b0;
            out_x   <= '0;
            out_y   <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        x_q     <= x_ext;
                        y_q     <= y_ext;
                        ent_q   <= rom_ent;
                        it_q    <= '0;
                        state_q <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    x_q     <= pre_x;
                    y_q     <= pre_y;
                    state_q <= (ent_q.n == '0) ? ST_FIN : ST_ITER;
                end
                ST_ITER: begin
                    x_q <= rot_x;
                    y_q <= rot_y;
                    if (last_step) begin
                        it_q    <= '0;
                        state_q <= ST_FIN;
                    end else begin
                        it_q <= it_q + CNT_W'(1);
                    end
                end
                default: begin
                    out_x   <= sat_x;
                    out_y   <= sat_y;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // R5: a result pulse never lasts two cycles.
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done is raised only on leaving the deliver state.
    a_r4_done_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q) == ST_FIN);

    // R4: the step pointer stays inside the listed iteration count.
    a_r4_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER) |-> (it_q < ent_q.n));

    // R6: the latched angle entry cannot change while busy.
    a_r6_entry_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(ent_q));

    // R6: a start seen while busy never restarts the sequence.
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> (state_q != ST_PRE));

endmodule

// File: tb/ts_cordic_rotator_tb.sv
`timescale 1ns/1ps
module ts_cordic_rotator_tb;

    localparam int TOL = 20;
    localparam real PI = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [3:0]         ang_idx = '0;
    logic signed [15:0] in_x = '0;
    logic signed [15:0] in_y = '0;
    logic               done;
    logic signed [15:0] out_x;
    logic signed [15:0] out_y;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    ts_cordic_rotator u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ang_idx(ang_idx),
        .in_x(in_x), .in_y(in_y), .done(done), .out_x(out_x), .out_y(out_y)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int clamp16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Exact rotation by idx*pi/16 counter-clockwise, rounded and clamped.
    function automatic int exp_rot(input int x, input int y, input int idx, input bit want_y);
        real th;
        real e;
        th = real'(idx) * PI / 16.0;
        e  = want_y ? (real'(x) * $sin(th) + real'(y) * $cos(th))
                    : (real'(x) * $cos(th) - real'(y) * $sin(th));
        return clamp16($rtoi(e >= 0.0 ? e + 0.5 : e - 0.5));
    endfunction

    function automatic int n_iter(input int idx);
        if (idx == 0 || idx == 8) return 0;
        if (idx == 1 || idx == 7 || idx == 9 || idx == 15) return 4;
        return 6;
    endfunction

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // One transaction: pulse start, count cycles to done, check the pulse width.
    task automatic do_op(input int xv, input int yv, input int iv,
                         output int ox, output int oy, output int lat, output bit one_cycle);
        @(negedge clk);
        in_x = 16'(xv); in_y = 16'(yv); ang_idx = 4'(iv); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        ox = int'(out_x);
        oy = int'(out_y);
        @(negedge clk);
        one_cycle = !done;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        wrap_up();
    end

    initial begin
        int vx [6] = '{30000, 0, 21000, -12345, 1000, -20000};
        int vy [6] = '{0, -30000, -21000, 23456, -2, -20000};
        int ox, oy, lat;
        bit pw;

        // R8: reset clears the outputs.
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8 done in reset", int'(done), 0);
        check(out_x == 16'sd0, "R8 out_x in reset", int'(out_x), 0);
        check(out_y == 16'sd0, "R8 out_y in reset", int'(out_y), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R8 done after reset", int'(done), 0);

        // R1/R4/R5: sweep every angle against several vectors.
        for (int i = 0; i < 16; i++) begin
            for (int v = 0; v < 6; v++) begin
                int ex, ey;
                do_op(vx[v], vy[v], i, ox, oy, lat, pw);
                ex = exp_rot(vx[v], vy[v], i, 1'b0);
                ey = exp_rot(vx[v], vy[v], i, 1'b1);
                check(absd(ox, ex) <= TOL, "R1 x accuracy", ox, ex);
                check(absd(oy, ey) <= TOL, "R1 y accuracy", oy, ey);
                check(lat == n_iter(i) + 2, "R4 latency", lat, n_iter(i) + 2);
                check(pw, "R5 done width", int'(!pw), 0);
            end
        end

        // R2: pass-through is bit-exact, including the most negative value.
        do_op(-32768, 32767, 0, ox, oy, lat, pw);
        check(ox == -32768, "R2 pass x", ox, -32768);
        check(oy == 32767, "R2 pass y", oy, 32767);
        do_op(123, -456, 0, ox, oy, lat, pw);
        check(ox == 123, "R2 pass x", ox, 123);
        check(oy == -456, "R2 pass y", oy, -456);

        // R3: quarter turn exact; R7 clamp of -(-32768).
        do_op(-32768, -32768, 8, ox, oy, lat, pw);
        check(ox == 32767, "R3 R7 quarter x", ox, 32767);
        check(oy == -32768, "R3 quarter y", oy, -32768);
        do_op(4321, -777, 8, ox, oy, lat, pw);
        check(ox == 777, "R3 quarter x", ox, 777);
        check(oy == 4321, "R3 quarter y", oy, 4321);

        // R7: 45 degree turn of a large diagonal overflows y.
        do_op(30000, 30000, 4, ox, oy, lat, pw);
        check(oy == 32767, "R7 clamp high", oy, 32767);
        check(absd(ox, 0) <= TOL, "R7 x near zero", ox, 0);
        do_op(-30000, -30000, 4, ox, oy, lat, pw);
        check(oy == -32768, "R7 clamp low", oy, -32768);

        // R9: outputs hold after done.
        repeat (6) @(negedge clk);
        check(out_y == -16'sd32768, "R9 hold y", int'(out_y), -32768);
        check(done == 1'b0, "R9 no spurious done", int'(done), 0);

        // R6: a second start while busy is dropped.
        begin
            int ex, ey, extra;
            @(negedge clk);
            in_x = 16'sd21000; in_y = -16'sd21000; ang_idx = 4'd2; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat = 0;
            @(negedge clk); lat++;
            in_x = -16'sd5000; in_y = 16'sd9000; ang_idx = 4'd5; start = 1'b1;
            @(negedge clk); lat++;
            start = 1'b0;
            while (!done && lat < 64) begin
                @(negedge clk);
                lat++;
            end
            ox = int'(out_x);
            oy = int'(out_y);
            ex = exp_rot(21000, -21000, 2, 1'b0);
            ey = exp_rot(21000, -21000, 2, 1'b1);
            check(absd(ox, ex) <= TOL, "R6 result x kept", ox, ex);
            check(absd(oy, ey) <= TOL, "R6 result y kept", oy, ey);
            check(lat == 8, "R6 latency kept", lat, 8);
            extra = 0;
            repeat (12) begin
                @(negedge clk);
                if (done) extra++;
            end
            check(extra == 0, "R6 no second done", extra, 0);
        end

        wrap_up();
    end

endmodule